// File: doc/BRIEF.md
# Skewed Conflict-Free Matrix Memory

This block stores a 16×16 matrix of words across 17 single-port banks. Element (i, j), where i is the row and j the column, is placed in bank (i + 4·j) mod 17 at word address i. With this skew the sixteen elements of any row, any column, the main diagonal or the anti-diagonal always fall in sixteen different banks. A whole line of the matrix can therefore be written or read in a single memory cycle, and no access ever has to be split or stalled.

A caller presents one access per cycle. It gives a line selector, a row or column number, a write strobe and sixteen write words. The sixteen word lanes always follow increasing element order along the selected line. Read data comes back one cycle later on sixteen lanes in that same order, because a crossbar undoes the bank skew. A conflict flag reports whether two lanes of the current access ever landed in one bank. It is a checking aid and stays low on a correct build.

Top module: `skew_matrix_mem`

## Requirements
- R1: With `acc_mode` = 0 (row), lane k addresses element (`acc_idx`, k). A write stores lane k's word there, and a read returns that element on lane k.
- R2: With `acc_mode` = 1 (column), lane k addresses element (k, `acc_idx`) for writes and reads.
- R3: With `acc_mode` = 2 (main diagonal), lane k addresses element (k, k). `acc_idx` is ignored, and a diagonal write leaves every element off the diagonal unchanged.
- R4: With `acc_mode` = 3 (anti-diagonal), lane k addresses element (k, 15 − k). `acc_idx` is ignored, and elements off the anti-diagonal are untouched.
- R5: A read request (`acc_valid` high, `acc_write` low) raises `rd_valid` for exactly the following cycle, and `rd_word` then holds the requested line. Lane k occupies bits [16k+15:16k]. Writes and idle cycles leave `rd_valid` low in the next cycle.
- R6: No access in any mode or index ever places two lanes in the same bank, so `conflict` stays low on every valid access.
- R7: Every valid access enables exactly 16 of the 17 banks, and no bank is enabled on an idle cycle.
- R8: Data written through one line direction reads back correctly through every other direction, so all four modes share one consistent element placement.
- R9: `rd_word` keeps its value on every cycle in which `rd_valid` is low, including after intervening writes.
- R10: After reset, `rd_valid` is low, `rd_word` is all zero and `conflict` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is requested this cycle |
| acc_write | input | 1 | 1 = write the line, 0 = read it |
| acc_mode | input | 2 | Line selector: 0 row, 1 column, 2 diagonal, 3 anti-diagonal |
| acc_idx | input | 4 | Row number (row mode) or column number (column mode) |
| wr_word | input | 256 | Sixteen write words, lane k in bits [16k+15:16k] |
| rd_valid | output | 1 | `rd_word` carries the line requested in the previous cycle |
| rd_word | output | 256 | Sixteen read words in element order, lane k in bits [16k+15:16k] |
| conflict | output | 1 | Two lanes of the current access target one bank |

## Verification
The bound properties assume that `acc_valid`, `acc_write` and `acc_mode` are known after reset. They also assume that requests are sampled at the rising edge, so the bank-occupancy and spare-bank checks read the selector in the same cycle as the enables. The bench drives every input from a defined value at the falling edge and drops `acc_valid` between accesses. This covers both the idle-cycle enable check and the hold property on `rd_word`. Because all four selector codes are legal, the stimulus walks each of them across every row and column number, including nonzero `acc_idx` in the two diagonal modes.

// File: rtl/skm_pkg.sv
package skm_pkg;

  typedef enum logic [1:0] {
    MODE_ROW  = 2'd0,
    MODE_COL  = 2'd1,
    MODE_DIAG = 2'd2,
    MODE_ANTI = 2'd3
  } line_mode_e;

  // Bank holding element (row, col) for a skew exponent p: (row + 2^p*col) mod (2^(2p)+1)
  function automatic int skew_bank(input int row, input int col, input int p);
    int nb;
    nb = (1 << (2 * p)) + 1;
    return (row + (col << p)) % nb;
  endfunction

  // Row coordinate of a lane within the selected line
  function automatic int line_row(input line_mode_e m, input int idx, input int lane);
    if (m == MODE_ROW) return idx;
    return lane;
  endfunction

  // Column coordinate of a lane within the selected line
  function automatic int line_col(input line_mode_e m, input int idx, input int lane,
                                  input int n);
    case (m)
      MODE_ROW:  return lane;
      MODE_COL:  return idx;
      MODE_DIAG: return lane;
      default:   return n - 1 - lane;
    endcase
  endfunction

endpackage

// File: rtl/skm_lane_map.sv
module skm_lane_map
  import skm_pkg::*;
#(
  parameter  int SKEW_P = 2,
  localparam int N      = 1 << (2 * SKEW_P),
  localparam int NB     = N + 1,
  localparam int IW     = $clog2(N),
  localparam int BW     = $clog2(NB)
) (
  input  line_mode_e             mode,
  input  logic [IW-1:0]          idx,
  output logic [N-1:0][IW-1:0]   lane_row,
  output logic [N-1:0][BW-1:0]   lane_bank
);

  for (genvar k = 0; k < N; k++) begin : g_lane
    int r_i;
    int c_i;
    always_comb begin
      r_i          = line_row(mode, int'(idx), k);
      c_i          = line_col(mode, int'(idx), k, N);
      lane_row[k]  = IW'(r_i);
      lane_bank[k] = BW'(skew_bank(r_i, c_i, SKEW_P));
    end
  end

endmodule

// File: rtl/skm_bank_route.sv
module skm_bank_route #(
  parameter  int SKEW_P = 2,
  parameter  int DATA_W = 16,
  localparam int N      = 1 << (2 * SKEW_P),
  localparam int NB     = N + 1,
  localparam int IW     = $clog2(N),
  localparam int BW     = $clog2(NB)
) (
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic [N-1:0][IW-1:0]      lane_row,
  input  logic [N-1:0][BW-1:0]      lane_bank,
  input  logic [N-1:0][DATA_W-1:0]  lane_wd,
  output logic [NB-1:0]             bank_en,
  output logic [NB-1:0]             bank_we,
  output logic [NB-1:0][IW-1:0]     bank_addr,
  output logic [NB-1:0][DATA_W-1:0] bank_wd,
  output logic                      conflict
);

  logic [NB-1:0] bank_multi;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_comb begin
      int hits;
      hits         = 0;
      bank_addr[b] = '0;
      bank_wd[b]   = '0;
      for (int k = 0; k < N; k++) begin
        if (lane_bank[k] == BW'(b)) begin
          hits         = hits + 1;
          bank_addr[b] = bank_addr[b] | lane_row[k];
          bank_wd[b]   = bank_wd[b] | lane_wd[k];
        end
      end
      bank_multi[b] = (hits > 1);
      bank_en[b]    = acc_valid && (hits != 0);
      bank_we[b]    = acc_valid && acc_write && (hits != 0);
    end
  end

  assign conflict = acc_valid && (|bank_multi);

endmodule

// File: rtl/skm_bank.sv
module skm_bank #(
  parameter  int DEPTH  = 16,
  parameter  int DATA_W = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd <= '0;
    else if (en && !we)  rd <= mem[addr];
  end

endmodule

// File: rtl/skm_read_xbar.sv
module skm_read_xbar #(
  parameter  int SKEW_P = 2,
  parameter  int DATA_W = 16,
  localparam int N      = 1 << (2 * SKEW_P),
  localparam int NB     = N + 1,
  localparam int BW     = $clog2(NB)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_req,
  input  logic [N-1:0][BW-1:0]      lane_bank,
  input  logic [NB-1:0][DATA_W-1:0] bank_rd,
  output logic                      rd_valid,
  output logic [N-1:0][DATA_W-1:0]  rd_lane
);

  logic [N-1:0][BW-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) sel_q <= lane_bank;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_out
    always_comb begin
      rd_lane[k] = '0;
      for (int b = 0; b < NB; b++) begin
        if (sel_q[k] == BW'(b)) rd_lane[k] = bank_rd[b];
      end
    end
  end

endmodule

// File: rtl/skew_matrix_mem.sv
module skew_matrix_mem
  import skm_pkg::*;
#(
  parameter  int SKEW_P = 2,
  parameter  int DATA_W = 16,
  localparam int N      = 1 << (2 * SKEW_P),
  localparam int NB     = N + 1,
  localparam int IW     = $clog2(N),
  localparam int BW     = $clog2(NB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [1:0]          acc_mode,
  input  logic [IW-1:0]       acc_idx,
  input  logic [N*DATA_W-1:0] wr_word,
  output logic                rd_valid,
  output logic [N*DATA_W-1:0] rd_word,
  output logic                conflict
);

  line_mode_e                mode;
  logic [N-1:0][IW-1:0]      lane_row;
  logic [N-1:0][BW-1:0]      lane_bank;
  logic [N-1:0][DATA_W-1:0]  lane_wd;
  logic [N-1:0][DATA_W-1:0]  rd_lane;
  logic [NB-1:0]             bank_en;
  logic [NB-1:0]             bank_we;
  logic [NB-1:0][IW-1:0]     bank_addr;
  logic [NB-1:0][DATA_W-1:0] bank_wd;
  logic [NB-1:0][DATA_W-1:0] bank_rd;
  logic                      rd_req;

  assign mode   = line_mode_e'(acc_mode);
  assign rd_req = acc_valid && !acc_write;

  for (genvar k = 0; k < N; k++) begin : g_io
    assign lane_wd[k]                = wr_word[k*DATA_W +: DATA_W];
    assign rd_word[k*DATA_W +: DATA_W] = rd_lane[k];
  end

  skm_lane_map #(.SKEW_P(SKEW_P)) u_map (
    .mode      (mode),
    .idx       (acc_idx),
    .lane_row  (lane_row),
    .lane_bank (lane_bank)
  );

  skm_bank_route #(.SKEW_P(SKEW_P), .DATA_W(DATA_W)) u_route (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .lane_row  (lane_row),
    .lane_bank (lane_bank),
    .lane_wd   (lane_wd),
    .bank_en   (bank_en),
    .bank_we   (bank_we),
    .bank_addr (bank_addr),
    .bank_wd   (bank_wd),
    .conflict  (conflict)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    skm_bank #(.DEPTH(N), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (bank_en[b]),
      .we    (bank_we[b]),
      .addr  (bank_addr[b]),
      .wd    (bank_wd[b]),
      .rd    (bank_rd[b])
    );
  end

  skm_read_xbar #(.SKEW_P(SKEW_P), .DATA_W(DATA_W)) u_xbar (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .lane_bank (lane_bank),
    .bank_rd   (bank_rd),
    .rd_valid  (rd_valid),
    .rd_lane   (rd_lane)
  );

endmodule

// File: rtl/skm_chk.sv
module skm_chk #(
  parameter  int SKEW_P = 2,
  parameter  int DATA_W = 16,
  localparam int N      = 1 << (2 * SKEW_P),
  localparam int NB     = N + 1,
  // A diagonal or anti-diagonal would reach this bank only at a 17th element
  localparam int SPARE  = (N + (1 << SKEW_P) * N) % NB
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acc_valid,
  input logic                acc_write,
  input logic [1:0]          acc_mode,
  input logic                conflict,
  input logic                rd_valid,
  input logic [N*DATA_W-1:0] rd_word,
  input logic [NB-1:0]       bank_en
);

  // R6
  no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> !conflict);

  // R7
  bank_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> ($countones(bank_en) == N));

  // R7
  idle_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (bank_en == '0));

  // R3 R4
  spare_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mode[1]) |-> !bank_en[SPARE]);

  // R5
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);

  // R5
  no_read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rd_valid);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_word));

endmodule

bind skew_matrix_mem skm_chk #(.SKEW_P(SKEW_P), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_mode  (acc_mode),
  .conflict  (conflict),
  .rd_valid  (rd_valid),
  .rd_word   (rd_word),
  .bank_en   (bank_en)
);

// File: tb/skew_matrix_mem_test.sv
module skew_matrix_mem_test;

  localparam int N = 16;
  localparam int W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_valid = 1'b0;
  logic             acc_write = 1'b0;
  logic [1:0]       acc_mode = 2'd0;
  logic [3:0]       acc_idx = 4'd0;
  logic [N*W-1:0]   wr_word = '0;
  logic             rd_valid;
  logic [N*W-1:0]   rd_word;
  logic             conflict;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [W-1:0] model [N][N];
  logic [W-1:0] wbuf [N];

  skew_matrix_mem uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_mode(acc_mode), .acc_idx(acc_idx), .wr_word(wr_word),
    .rd_valid(rd_valid), .rd_word(rd_word), .conflict(conflict)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Element coordinates of lane k, written from the requirement table
  function automatic int coord_r(input int m, input int ix, input int k);
    return (m == 0) ? ix : k;
  endfunction
  function automatic int coord_c(input int m, input int ix, input int k);
    if (m == 0) return k;
    if (m == 1) return ix;
    if (m == 2) return k;
    return 15 - k;
  endfunction

  task automatic access(input int m, input int ix, input bit wr, input string req);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = wr;
    acc_mode  = 2'(m);
    acc_idx   = 4'(ix);
    for (int k = 0; k < N; k++) wr_word[k*W +: W] = wbuf[k];
    #1;
    check(conflict == 1'b0, "R6", W'(conflict), '0);
    @(negedge clk);
    acc_valid = 1'b0;
    if (wr) begin
      check(rd_valid == 1'b0, "R5", W'(rd_valid), '0);
      for (int k = 0; k < N; k++) model[coord_r(m, ix, k)][coord_c(m, ix, k)] = wbuf[k];
    end else begin
      check(rd_valid == 1'b1, "R5", W'(rd_valid), 16'd1);
      for (int k = 0; k < N; k++) begin
        logic [W-1:0] e;
        e = model[coord_r(m, ix, k)][coord_c(m, ix, k)];
        check(rd_word[k*W +: W] == e, req, rd_word[k*W +: W], e);
      end
    end
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < N; i++) access(0, i, 1'b0, req);
    for (int j = 0; j < N; j++) access(1, j, 1'b0, req);
    access(2, 5, 1'b0, req);
    access(3, 11, 1'b0, req);
  endtask

  initial begin
    logic [N*W-1:0] held;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) model[i][j] = 'x;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(rd_valid == 1'b0, "R10", W'(rd_valid), '0);
    check(conflict == 1'b0, "R10", W'(conflict), '0);
    check(rd_word == '0, "R10", rd_word[W-1:0], '0);
    rst_n = 1'b1;

    // R1: fill by rows, then read every direction (R8 cross-direction)
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < N; k++) wbuf[k] = W'((i << 12) | (k << 8) | 8'h11);
      access(0, i, 1'b1, "R1");
    end
    for (int i = 0; i < N; i++) access(0, i, 1'b0, "R1");
    for (int j = 0; j < N; j++) access(1, j, 1'b0, "R8");
    access(2, 0, 1'b0, "R8");
    access(3, 0, 1'b0, "R8");

    // R2: refill by columns, check through rows
    for (int j = 0; j < N; j++) begin
      for (int k = 0; k < N; k++) wbuf[k] = W'((k << 12) | (j << 8) | 8'h22);
      access(1, j, 1'b1, "R2");
    end
    for (int j = 0; j < N; j++) access(1, j, 1'b0, "R2");
    for (int i = 0; i < N; i++) access(0, i, 1'b0, "R8");

    // R3: diagonal write with nonzero index; off-diagonal must survive
    for (int k = 0; k < N; k++) wbuf[k] = W'((k << 8) | 8'h33);
    access(2, 9, 1'b1, "R3");
    for (int i = 0; i < N; i++) access(0, i, 1'b0, "R3");
    access(2, 14, 1'b0, "R3");

    // R4: anti-diagonal write with nonzero index
    for (int k = 0; k < N; k++) wbuf[k] = W'((k << 8) | 8'h44);
    access(3, 3, 1'b1, "R4");
    for (int j = 0; j < N; j++) access(1, j, 1'b0, "R4");
    access(3, 7, 1'b0, "R4");

    // Diagonal and anti-diagonal under every index value
    for (int ix = 0; ix < N; ix++) begin
      access(2, ix, 1'b0, "R3");
      access(3, ix, 1'b0, "R4");
    end
    read_all("R8");

    // R9: output held across writes and idle cycles
    access(0, 6, 1'b0, "R9");
    held = rd_word;
    for (int k = 0; k < N; k++) wbuf[k] = W'(16'hBEE0 + k);
    access(1, 2, 1'b1, "R9");
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0, "R5", W'(rd_valid), '0);
    check(rd_word == held, "R9", rd_word[W-1:0], held[W-1:0]);
    access(0, 6, 1'b0, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule